// File: doc/BRIEF.md
# 4:2:2 Sixteen-Bit Pixel Output Port

This block is the last stage of a video decoder's pixel path. Samples arrive from an upstream rate converter in irregular bursts. Each one carries a luma byte and both chroma components. The block presents them on a 16-bit synchronous output. One lane carries 8-bit luma. The other carries one chroma byte per sample, alternating blue-difference and red-difference. A valid strobe marks each clock that carries a real sample. Idle clocks leave the data lanes frozen.

The chroma lane is not multiplexed on every clock. The selection advances only when a sample is valid, so a pair always starts with Cb, however many idle clocks fall between its two halves. A line-start pulse from the timing logic realigns the pair to Cb at the start of every line.

A visible-region flag arrives from a separate timing block. It is registered with the same one-clock latency as the data, so it stays aligned to the data. Downstream logic can then capture only the visible picture (valid and flag both high) or every valid sample, including blanking and burst-reference intervals (valid alone). The clock this block runs on in the system is in the 20 to 30 MHz range.

Top module: `pix422_out_port`

## Requirements
- R1: A synchronous active-high reset makes the output valid strobe, the visible flag, both data lanes and the chroma selection clear. After reset the first valid sample carries Cb on the chroma lane.
- R2: The output valid strobe equals the input sample-valid of the previous clock, bursts and gaps included.
- R3: On the clock after a valid input sample, the luma lane (bits 15:8 of the combined word) shows that sample's luma byte.
- R4: The chroma lane (bits 7:0) carries Cb for the first valid sample of a pair and Cr for the second. Only valid samples advance the selection, so idle clocks between them do not change it.
- R5: A line-start pulse forces the selection back to Cb. If a valid sample arrives on the same clock as the pulse, that sample carries Cb and the next valid sample carries Cr.
- R6: While the input sample-valid is low, both data lanes hold their last value.
- R7: The visible-region output equals the visible-region input of the previous clock, whatever the valid strobe is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Upstream sample present this clock |
| smp_luma | input | 8 | Luma byte of the upstream sample |
| smp_cb | input | 8 | Blue-difference byte of the upstream sample |
| smp_cr | input | 8 | Red-difference byte of the upstream sample |
| line_start | input | 1 | One-clock pulse at the start of a line; realigns chroma to Cb |
| act_in | input | 1 | Visible-region flag from the timing block |
| px_vld | output | 1 | Output word carries a sample |
| px_luma | output | 8 | Luma lane of the 16-bit output |
| px_chroma | output | 8 | Multiplexed chroma lane of the 16-bit output |
| px_act | output | 1 | Visible-region flag aligned to the output word |

## Verification
An unbroken burst of valid samples checks that the chroma lane toggles on every clock. Sparse patterns with one- and two-clock gaps separate a selection that advances only on valid samples from one that advances on every clock. Line-start pulses are placed after an odd count of samples, on an idle clock and on a valid clock, to show that realignment happens and takes effect on the coinciding sample. A long pseudo-random stream with an independently toggling visible flag, plus a reset in mid-stream, checks that the flag is aligned no matter what the valid strobe does and that the port recovers.

// File: rtl/pix422_pkg.sv
package pix422_pkg;
   typedef enum logic {
      PH_CB = 1'b0,
      PH_CR = 1'b1
   } chroma_ph_e;

   function automatic chroma_ph_e other_ph(input chroma_ph_e p);
      return (p == PH_CB) ? PH_CR : PH_CB;
   endfunction
endpackage

// File: rtl/pix422_phase.sv
module pix422_phase
   import pix422_pkg::*;
#(
   parameter bit CB_FIRST = 1'b1
)(
   input  logic       clk,
   input  logic       rst,
   input  logic       smp_vld,
   input  logic       line_start,
   output chroma_ph_e cur_ph
);
   chroma_ph_e start_ph;
   chroma_ph_e ph_q;
   chroma_ph_e ph_d;

   generate
      if (CB_FIRST) begin : g_cb_lead
         assign start_ph = PH_CB;
      end else begin : g_cr_lead
         assign start_ph = PH_CR;
      end
   endgenerate

   // Phase used by the sample on this clock; a line start overrides state.
   always_comb begin
      cur_ph = line_start ? start_ph : ph_q;
      ph_d   = cur_ph;
      if (smp_vld) ph_d = other_ph(cur_ph);
   end

   always_ff @(posedge clk) begin
      if (rst) ph_q <= start_ph;
      else     ph_q <= ph_d;
   end

   AST_RST_PHASE: assert property (@(posedge clk) rst |=> ph_q == start_ph); // R1
   AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      smp_vld && !line_start |=> ph_q != $past(ph_q)); // R4
   AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !smp_vld && !line_start |=> $stable(ph_q)); // R4
   AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
      line_start && !smp_vld |=> ph_q == start_ph); // R5
   AST_LINE_VALID: assert property (@(posedge clk) disable iff (rst)
      line_start && smp_vld |=> ph_q != start_ph); // R5
endmodule

// File: rtl/pix422_lanes.sv
module pix422_lanes
   import pix422_pkg::*;
#(
   parameter int LUMA_W   = 8,
   parameter int CHROMA_W = 8
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_vld,
   input  logic [LUMA_W-1:0]   smp_luma,
   input  logic [CHROMA_W-1:0] smp_cb,
   input  logic [CHROMA_W-1:0] smp_cr,
   input  chroma_ph_e          sel_ph,
   input  logic                act_in,
   output logic                px_vld,
   output logic [LUMA_W-1:0]   px_luma,
   output logic [CHROMA_W-1:0] px_chroma,
   output logic                px_act
);
   logic [CHROMA_W-1:0] chroma_pick;

   assign chroma_pick = (sel_ph == PH_CR) ? smp_cr : smp_cb;

   always_ff @(posedge clk) begin
      if (rst) begin
         px_vld    <= 1'b0;
         px_act    <= 1'b0;
         px_luma   <= '0;
         px_chroma <= '0;
      end else begin
         px_vld <= smp_vld;
         px_act <= act_in;
         if (smp_vld) begin
            px_luma   <= smp_luma;
            px_chroma <= chroma_pick;
         end
      end
   end

   AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> px_vld == $past(smp_vld)); // R2
   AST_LUMA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> px_luma == $past(smp_luma)); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> $stable(px_luma) && $stable(px_chroma)); // R6
   AST_ACT_ALIGN: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> px_act == $past(act_in)); // R7
endmodule

// File: rtl/pix422_out_port.sv
module pix422_out_port
   import pix422_pkg::*;
#(
   parameter int LUMA_W   = 8,
   parameter int CHROMA_W = 8,
   parameter bit CB_FIRST = 1'b1
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_vld,
   input  logic [LUMA_W-1:0]   smp_luma,
   input  logic [CHROMA_W-1:0] smp_cb,
   input  logic [CHROMA_W-1:0] smp_cr,
   input  logic                line_start,
   input  logic                act_in,
   output logic                px_vld,
   output logic [LUMA_W-1:0]   px_luma,
   output logic [CHROMA_W-1:0] px_chroma,
   output logic                px_act
);
   localparam int WORD_W = LUMA_W + CHROMA_W;

   generate
      if (LUMA_W < 1 || CHROMA_W < 1) begin : g_bad_width
         $error("pix422_out_port: lane widths must be at least 1");
      end
      if (WORD_W > 64) begin : g_bad_word
         $error("pix422_out_port: combined word wider than 64 bits");
      end
   endgenerate

   chroma_ph_e cur_ph;

   pix422_phase #(.CB_FIRST(CB_FIRST)) u_phase (
      .clk        (clk),
      .rst        (rst),
      .smp_vld    (smp_vld),
      .line_start (line_start),
      .cur_ph     (cur_ph)
   );

   pix422_lanes #(.LUMA_W(LUMA_W), .CHROMA_W(CHROMA_W)) u_lanes (
      .clk       (clk),
      .rst       (rst),
      .smp_vld   (smp_vld),
      .smp_luma  (smp_luma),
      .smp_cb    (smp_cb),
      .smp_cr    (smp_cr),
      .sel_ph    (cur_ph),
      .act_in    (act_in),
      .px_vld    (px_vld),
      .px_luma   (px_luma),
      .px_chroma (px_chroma),
      .px_act    (px_act)
   );

   AST_RST_OUTPUTS: assert property (@(posedge clk)
      rst |=> !px_vld && !px_act && px_luma == '0 && px_chroma == '0); // R1
endmodule

// File: tb/sim_pix422_out_port.sv
module sim_pix422_out_port;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       smp_vld = 1'b0;
   logic [7:0] smp_luma = '0;
   logic [7:0] smp_cb = '0;
   logic [7:0] smp_cr = '0;
   logic       line_start = 1'b0;
   logic       act_in = 1'b0;
   logic       px_vld;
   logic [7:0] px_luma;
   logic [7:0] px_chroma;
   logic       px_act;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   int m_vld = 0, m_act = 0, m_ph = 0, m_y = 0, m_c = 0;
   int lcg = 32'h1234_5678;

   always #4 clk = ~clk;

   pix422_out_port u0 (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_luma(smp_luma),
      .smp_cb(smp_cb), .smp_cr(smp_cr), .line_start(line_start),
      .act_in(act_in), .px_vld(px_vld), .px_luma(px_luma),
      .px_chroma(px_chroma), .px_act(px_act)
   );

   task automatic chk(input string tag, input string what, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, actual, expected, $time);
      end
   endtask

   // One clock: drive at negedge, model at posedge, compare at next negedge.
   task automatic cyc(input bit r, input bit v, input bit ls, input bit a,
                      input int y, input int cb, input int cr);
      int ph;
      rst = r; smp_vld = v; line_start = ls; act_in = a;
      smp_luma = y[7:0]; smp_cb = cb[7:0]; smp_cr = cr[7:0];
      @(posedge clk);
      if (r) begin
         m_vld = 0; m_act = 0; m_ph = 0; m_y = 0; m_c = 0;
      end else begin
         ph = ls ? 0 : m_ph;
         m_vld = v; m_act = a;
         if (v) begin
            m_y = y & 255;
            m_c = (ph == 1) ? (cr & 255) : (cb & 255);
            ph = 1 - ph;
         end
         m_ph = ph;
      end
      @(negedge clk);
      if (r) begin
         chk("R1", "vld", px_vld, 0);
         chk("R1", "act", px_act, 0);
         chk("R1", "luma", px_luma, 0);
         chk("R1", "chroma", px_chroma, 0);
      end else begin
         chk("R2", "vld", px_vld, m_vld);
         chk("R7", "act", px_act, m_act);
         chk(v ? "R3" : "R6", "luma", px_luma, m_y);
         chk(ls ? "R5" : (v ? "R4" : "R6"), "chroma", px_chroma, m_c);
      end
   endtask

   function automatic int rnd();
      lcg = lcg * 1103515245 + 12345;
      return (lcg >>> 8) & 32'h7fff;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1: reset with busy inputs
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1, 8'h55, 8'h66, 8'h77);
      // R1: first sample after reset carries Cb
      cyc(0, 1, 0, 1, 10, 20, 30);
      cyc(0, 1, 0, 1, 11, 21, 31);
      // R4: continuous burst
      for (int i = 0; i < 8; i++) cyc(0, 1, 0, i % 2, 40 + i, 100 + i, 200 + i);
      // R4, R6: sparse samples with gaps
      cyc(0, 1, 0, 1, 60, 61, 62);
      cyc(0, 0, 0, 1, 99, 98, 97);
      cyc(0, 0, 0, 0, 96, 95, 94);
      cyc(0, 1, 0, 0, 63, 64, 65);
      cyc(0, 0, 0, 1, 1, 2, 3);
      cyc(0, 1, 0, 1, 66, 67, 68);
      // R5: line start on idle clock after odd count
      cyc(0, 0, 1, 0, 5, 6, 7);
      cyc(0, 1, 0, 0, 70, 71, 72);
      cyc(0, 1, 0, 0, 73, 74, 75);
      cyc(0, 1, 0, 0, 76, 77, 78);
      // R5: line start coinciding with a valid sample
      cyc(0, 1, 1, 1, 80, 81, 82);
      cyc(0, 1, 0, 1, 83, 84, 85);
      // R7: flag toggles while valid is low
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, i % 2, 9, 9, 9);
      // pseudo-random stream
      for (int i = 0; i < 3000; i++)
         cyc(0, rnd() % 3 != 0, rnd() % 37 == 0, rnd() % 2, rnd(), rnd(), rnd());
      // R1: reset mid-stream at Cr phase, then restart on Cb
      cyc(0, 1, 1, 1, 1, 2, 3);
      cyc(1, 1, 0, 1, 4, 5, 6);
      cyc(0, 1, 0, 1, 7, 8, 9);
      cyc(0, 1, 0, 0, 10, 11, 12);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule